// File: doc/BRIEF.md
# Double-Buffered Corner-Turn Memory

This block sits between the range stage and the azimuth stage of a radar image processor and transposes each frame. The range stage delivers one pulse at a time as it finishes, each sample tagged with its pulse number and range-bin number. The azimuth stage needs the same frame back one range bin at a time, with all pulses of that bin in order. Storing a pulse the moment it arrives spreads the memory traffic over the whole frame period. The alternative is to move the whole matrix at frame end, which creates a traffic peak.

Two frame-sized banks alternate roles. The writer fills one bank while the reader drains the other. A bank becomes readable only after every sample of its frame has been accepted. The roles swap only when the writer has a finished frame and the reader has emptied its bank. If the writer reaches the end of a frame and the other bank still holds data, it stalls through `wr_ready`.

Frame height (pulses) and width (range bins) are parameters. A full-size instance is 512 pulses by 2048 bins of 64-bit complex values.

Top module: `corner_turn_buffer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `wr_ready` is 1, and `rd_valid`, `frame_ready` and `wr_frame_done` are 0.
- R2: A sample accepted with pulse index p and bin index b is stored at that position whatever order the samples of a frame arrive in. It is returned as the p-th sample of column b.
- R3: Each frame is read in column order. Bin index runs from 0 to N_BINS-1, and within a bin the pulse index runs from 0 to N_PULSES-1.
- R4: `rd_sop` is 1 exactly on the first sample (pulse 0) of every column. `rd_eof` is 1 only on the last sample of a frame (last pulse, last bin).
- R5: `frame_ready` and `rd_valid` stay 0 until the last sample of a frame has been accepted. `rd_valid` never rises unless `frame_ready` was 1 in the cycle before.
- R6: `wr_frame_done` is a one-cycle pulse in the cycle after the final sample of a frame is accepted (sample count reaching N_PULSES*N_BINS).
- R7: A second frame can be written while the first is waiting or being read. When both banks hold complete frames, `wr_ready` is 0 until the reader drains its bank.
- R8: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid`, `rd_data`, `rd_sop` and `rd_eof` hold their values.
- R9: Frames come out whole, one after another, in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Write sample present |
| wr_ready | output | 1 | Write sample can be accepted |
| wr_pulse | input | $clog2(N_PULSES) | Pulse (row) index of the write sample |
| wr_bin | input | $clog2(N_BINS) | Range-bin (column) index of the write sample |
| wr_data | input | DATA_W | Write sample value |
| wr_frame_done | output | 1 | One-cycle pulse after a frame's last sample is accepted |
| frame_ready | output | 1 | A complete frame is held for reading |
| rd_valid | output | 1 | Read sample present |
| rd_ready | input | 1 | Consumer takes the read sample |
| rd_data | output | DATA_W | Read sample value |
| rd_sop | output | 1 | Read sample is the first of its column |
| rd_eof | output | 1 | Read sample is the last of its frame |

## Verification
The bench builds the block with 64 pulses by 256 bins and a 32-bit data path, one sixty-fourth of a full frame. At that size three whole frames, about 49k samples, can be pushed through and every sample checked. Each value encodes its frame, pulse and bin, so misplacement, wrong ordering and frame mixing all show up as a wrong value.

The three frames use forward, reversed and even-then-odd bin orders within each pulse. Holding the reader off while two frames are written makes the both-banks-full stall reachable. A pseudo-random ready pattern on the read side then exercises the output hold.

// File: rtl/ct_pkg.sv
// Shared types for the corner-turn buffer.
// Assumes exactly two banks (ping-pong); the bank id is one bit.
package ct_pkg;
    localparam int NUM_BANKS = 2;
    typedef logic [NUM_BANKS-1:0] bank_vec_t;
    typedef struct packed {
        logic sop;
        logic eof;
    } rd_flags_t;
endpackage

// File: rtl/ct_bank.sv
// One frame bank: synchronous write, registered synchronous read.
// Assumes writer and reader never address the same bank in one cycle.
module ct_bank #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store an accepted sample.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Fetch a sample into the read register; hold it otherwise.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/ct_writer.sv
// Write side: places each sample at pulse*N_BINS+bin in the current bank,
// counts samples, marks the bank full and switches bank at frame end.
// Assumes indices from the source are in range; stalls while its bank is full.
module ct_writer #(
    parameter int N_PULSES = 4,
    parameter int N_BINS   = 8,
    localparam int PW    = $clog2(N_PULSES),
    localparam int BW    = $clog2(N_BINS),
    localparam int TOTAL = N_PULSES * N_BINS,
    localparam int AW    = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [PW-1:0]     wr_pulse,
    input  logic [BW-1:0]     wr_bin,
    input  ct_pkg::bank_vec_t bank_full,
    output logic              wr_ready,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output logic              wsel,
    output logic              set_full,
    output logic              frame_done
);
    logic [AW-1:0] cnt;
    logic          last;

    // Accept only into a bank that holds no unread frame.
    always_comb begin
        wr_ready = !bank_full[wsel];
        we       = wr_valid && wr_ready;
        waddr    = AW'(wr_pulse) * AW'(N_BINS) + AW'(wr_bin);
        last     = (cnt == AW'(TOTAL - 1));
        set_full = we && last;
    end

    // Count samples, swap bank and flag completion at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            wsel       <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= set_full;
            if (we) begin
                cnt <= last ? '0 : cnt + 1'b1;
                if (last) wsel <= ~wsel;
            end
        end
    end

    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (int'(wr_pulse) < N_PULSES && int'(wr_bin) < N_BINS));
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

// File: rtl/ct_reader.sv
// Read side: walks a full bank column by column (pulse fastest), one-entry
// output register with valid/ready, releases the bank after its last fetch.
// Assumes the bank it reads was marked full by the writer.
module ct_reader #(
    parameter int N_PULSES = 4,
    parameter int N_BINS   = 8,
    parameter int DATA_W   = 32,
    localparam int PW    = $clog2(N_PULSES),
    localparam int BW    = $clog2(N_BINS),
    localparam int TOTAL = N_PULSES * N_BINS,
    localparam int AW    = $clog2(TOTAL)
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  ct_pkg::bank_vec_t                           bank_full,
    input  logic [ct_pkg::NUM_BANKS-1:0][DATA_W-1:0]    bank_rdata,
    input  logic                                        rd_ready,
    output ct_pkg::bank_vec_t                           re,
    output logic [AW-1:0]                               raddr,
    output logic                                        rsel,
    output logic                                        clr_full,
    output logic                                        rd_valid,
    output logic [DATA_W-1:0]                           rd_data,
    output logic                                        rd_sop,
    output logic                                        rd_eof
);
    logic [PW-1:0]    rp;
    logic [BW-1:0]    rb;
    logic             issue;
    logic             col_end;
    logic             frm_end;
    logic             rsel_q;
    ct_pkg::rd_flags_t flags_q;

    // Fetch when a frame is held and the output register is free or leaving.
    always_comb begin
        issue    = bank_full[rsel] && (!rd_valid || rd_ready);
        col_end  = (rp == PW'(N_PULSES - 1));
        frm_end  = col_end && (rb == BW'(N_BINS - 1));
        raddr    = AW'(rp) * AW'(N_BINS) + AW'(rb);
        clr_full = issue && frm_end;
        for (int i = 0; i < ct_pkg::NUM_BANKS; i++)
            re[i] = issue && (rsel == 1'(i));
        rd_data = bank_rdata[rsel_q];
        rd_sop  = flags_q.sop;
        rd_eof  = flags_q.eof;
    end

    // Advance column-major indices, output valid and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp       <= '0;
            rb       <= '0;
            rsel     <= 1'b0;
            rsel_q   <= 1'b0;
            rd_valid <= 1'b0;
            flags_q  <= '0;
        end else if (issue) begin
            rd_valid    <= 1'b1;
            rsel_q      <= rsel;
            flags_q.sop <= (rp == '0);
            flags_q.eof <= frm_end;
            rp          <= col_end ? '0 : rp + 1'b1;
            if (col_end) rb <= frm_end ? '0 : rb + 1'b1;
            if (frm_end) rsel <= ~rsel;
        end else if (rd_ready) begin
            rd_valid <= 1'b0;
        end
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)
                                     && $stable(rd_sop) && $stable(rd_eof)));
    p_sop_after_eof_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && rd_eof) |=> (!rd_valid || rd_sop));
endmodule

// File: rtl/corner_turn_buffer.sv
// Ping-pong corner-turn buffer: pulses written row-wise into one bank while
// the other bank is read out column-wise. Banks swap only when the written
// frame is complete and the read bank has drained.
// Assumes N_PULSES >= 2 and N_BINS >= 2.
module corner_turn_buffer #(
    parameter int N_PULSES = 4,
    parameter int N_BINS   = 8,
    parameter int DATA_W   = 32,
    localparam int PW    = $clog2(N_PULSES),
    localparam int BW    = $clog2(N_BINS),
    localparam int TOTAL = N_PULSES * N_BINS,
    localparam int AW    = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [PW-1:0]     wr_pulse,
    input  logic [BW-1:0]     wr_bin,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_frame_done,
    output logic              frame_ready,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_sop,
    output logic              rd_eof
);
    ct_pkg::bank_vec_t                           bank_full;
    ct_pkg::bank_vec_t                           re;
    logic [ct_pkg::NUM_BANKS-1:0][DATA_W-1:0]    bank_rdata;
    logic                                        we;
    logic [AW-1:0]                               waddr;
    logic [AW-1:0]                               raddr;
    logic                                        wsel;
    logic                                        rsel;
    logic                                        set_full;
    logic                                        clr_full;

    ct_writer #(.N_PULSES(N_PULSES), .N_BINS(N_BINS)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_pulse(wr_pulse),
        .wr_bin(wr_bin), .bank_full(bank_full), .wr_ready(wr_ready), .we(we),
        .waddr(waddr), .wsel(wsel), .set_full(set_full), .frame_done(wr_frame_done)
    );

    ct_reader #(.N_PULSES(N_PULSES), .N_BINS(N_BINS), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .bank_full(bank_full), .bank_rdata(bank_rdata),
        .rd_ready(rd_ready), .re(re), .raddr(raddr), .rsel(rsel),
        .clr_full(clr_full), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_sop(rd_sop), .rd_eof(rd_eof)
    );

    for (genvar g = 0; g < ct_pkg::NUM_BANKS; g++) begin : g_bank
        ct_bank #(.DATA_W(DATA_W), .DEPTH(TOTAL), .AW(AW)) u_bank (
            .clk(clk), .we(we && (wsel == 1'(g))), .waddr(waddr), .wdata(wr_data),
            .re(re[g]), .raddr(raddr), .rdata(bank_rdata[g])
        );
    end

    // Track which banks hold a complete, not yet drained frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_full <= '0;
        end else begin
            for (int i = 0; i < ct_pkg::NUM_BANKS; i++) begin
                if (set_full && wsel == 1'(i)) bank_full[i] <= 1'b1;
                else if (clr_full && rsel == 1'(i)) bank_full[i] <= 1'b0;
            end
        end
    end

    // A frame is offered whenever the reader's bank is complete.
    assign frame_ready = bank_full[rsel];

    p_rd_after_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(frame_ready));
    p_banks_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && frame_ready) |-> (wsel != rsel));
    p_no_write_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_full == 2'b11) |-> !wr_ready);
endmodule

// File: tb/tb_corner_turn_buffer.sv
module tb_corner_turn_buffer;
    localparam int NP  = 64;
    localparam int NB  = 256;
    localparam int DW  = 32;
    localparam int TOT = NP * NB;
    localparam int PW  = $clog2(NP);
    localparam int BW  = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [PW-1:0] wr_pulse = '0;
    logic [BW-1:0] wr_bin = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_frame_done;
    logic          frame_ready;
    logic          rd_valid;
    logic          rd_ready = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_sop;
    logic          rd_eof;

    int n_chk = 0;
    int n_bad = 0;

    corner_turn_buffer #(.N_PULSES(NP), .N_BINS(NB), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_pulse(wr_pulse), .wr_bin(wr_bin), .wr_data(wr_data),
        .wr_frame_done(wr_frame_done), .frame_ready(frame_ready),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .rd_sop(rd_sop), .rd_eof(rd_eof)
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] pat(int f, int p, int b);
        return DW'((f << 24) | (p << 12) | b);
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Write one frame; mode picks bin order inside each pulse (R2).
    task automatic write_frame(int f, int mode, bit first);
        for (int k = 0; k < TOT; k++) begin
            int p = k / NB;
            int j = k % NB;
            int b = (mode == 0) ? j : (mode == 1) ? (NB - 1 - j)
                  : ((j < NB / 2) ? 2 * j : 2 * (j - NB / 2) + 1);
            @(negedge clk);
            wr_valid = 1'b1;
            wr_pulse = PW'(p);
            wr_bin   = BW'(b);
            wr_data  = pat(f, p, b);
            while (!wr_ready) @(negedge clk);
            if (first && k == TOT - 1) begin
                chk(frame_ready == 1'b0, "R5 frame_ready before last", frame_ready, 0);
                chk(rd_valid == 1'b0, "R5 rd_valid before last", rd_valid, 0);
                chk(wr_frame_done == 1'b0, "R6 done early", wr_frame_done, 0);
            end
        end
        @(negedge clk);
        wr_valid = 1'b0;
        chk(wr_frame_done == 1'b1, "R6 done pulse", wr_frame_done, 1);
        chk(frame_ready == 1'b1, "R5 frame_ready after last", frame_ready, 1);
    endtask

    // Drain nf frames with a pseudo-random ready pattern (R3 R4 R8 R9).
    task automatic read_frames(int nf);
        logic [15:0]   lfsr = 16'hACE1;
        bit            held = 1'b0;
        logic [DW-1:0] held_d = '0;
        int            f = 0;
        int            k = 0;
        while (f < nf) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (held)
                chk(rd_valid && rd_data == held_d, "R8 hold", rd_data, held_d);
            rd_ready = (lfsr[1:0] != 2'b00);
            if (rd_valid && rd_ready) begin
                int b = k / NP;
                int p = k % NP;
                chk(rd_data == pat(f, p, b), "R2 R3 R9 data", rd_data, pat(f, p, b));
                chk(rd_sop == (p == 0), "R4 sop", rd_sop, (p == 0));
                chk(rd_eof == (k == TOT - 1), "R4 eof", rd_eof, (k == TOT - 1));
                k++;
                if (k == TOT) begin
                    k = 0;
                    f++;
                end
            end
            held   = rd_valid && !rd_ready;
            held_d = rd_data;
        end
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
        chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        chk(frame_ready == 1'b0, "R1 frame_ready", frame_ready, 0);
        chk(wr_frame_done == 1'b0, "R1 done", wr_frame_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_ready == 1'b1 && rd_valid == 1'b0, "R1 after release", rd_valid, 0);

        // Phase A: reader held off, two frames fill both banks.
        write_frame(0, 0, 1'b1);
        write_frame(1, 1, 1'b0);
        @(negedge clk);
        chk(wr_ready == 1'b0, "R7 stall both full", wr_ready, 0);
        chk(rd_valid == 1'b1, "R5 first sample offered", rd_valid, 1);
        chk(rd_sop == 1'b1, "R4 first sop", rd_sop, 1);
        chk(rd_data == pat(0, 0, 0), "R3 first sample", rd_data, pat(0, 0, 0));
        repeat (5) begin
            @(negedge clk);
            chk(rd_valid && rd_data == pat(0, 0, 0), "R8 stalled output", rd_data, pat(0, 0, 0));
            chk(wr_ready == 1'b0, "R7 stall persists", wr_ready, 0);
        end

        // Phase B: third frame waits for a bank while three frames drain.
        fork
            write_frame(2, 2, 1'b0);
            read_frames(3);
        join
        @(negedge clk);
        chk(frame_ready == 1'b0 && rd_valid == 1'b0, "R9 all drained", frame_ready, 0);
        chk(wr_ready == 1'b1, "R7 writer free after drain", wr_ready, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule